// File: doc/BRIEF.md
# SAR Frequency Calibration Controller

This block tunes the frequency control code of a frequency-locked loop by successive approximation. It brings the loop's monitor clock into the reference clock domain and counts the monitor's rising edges over a fixed window of reference cycles. At the end of the window it compares that count with a programmable target. If the oscillator is too slow, which means the count is below the target, the bit under trial is kept. Otherwise it is cleared. In the same step the next lower bit is set as the new trial.

A calibration starts when the enable input goes high. The code starts at its midpoint, with only the top bit set, and the trial mask starts at that bit. After one decision per code bit, the done flag rises and the code is frozen. Lowering the enable aborts a calibration or releases a finished one, and returns everything to the starting point.

Top module: `sarcal_ctrl`

## Requirements
- R1: While reset is active, or on the clock edge after enable is sampled low, the code is 8'h80, the trial mask is 8'h80 and done is 0.
- R2: Each measurement window lasts exactly WIN_CYCLES reference cycles. With enable first sampled high at edge k, the mask first changes after edge k+WIN_CYCLES-1, and done rises after edge k+8*WIN_CYCLES-1.
- R3: When the window count is below the target, the trial bit stays set and the next lower bit is set. A target one above the count keeps the bit.
- R4: When the window count is equal to or above the target, the trial bit is cleared and the next lower bit is set. A count equal to the target clears the bit.
- R5: The trial mask is one-hot while calibrating. It moves one position toward bit 0 per decision and is 0 once done is high.
- R6: Only rising edges of the synchronized monitor clock are counted. A monitor held at a constant level gives a count of 0.
- R7: The window count saturates at 511 and does not wrap.
- R8: After the bit-0 decision, done stays high and the code stays unchanged for as long as enable stays high.
- R9: Lowering enable in the middle of a calibration returns the block to the R1 state on the next edge. Raising it again starts a fresh full-length first window.
- R10: While the mask is nonzero, the code bit at the mask position is 1 and every code bit below it is 0. Decisions never change code bits above the trial bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| cal_en | input | 1 | Calibration enable, synchronous to clk_ref |
| mon_clk | input | 1 | Monitor clock from the oscillator, asynchronous |
| target_cnt | input | 9 | Target number of monitor edges per window |
| tune_code | output | 8 | Frequency control code |
| trial_mask | output | 8 | One-hot position of the bit under trial, 0 when done |
| cal_done | output | 1 | High once every code bit has been decided |

## Verification
A wrong decision shows at the ports one window after it is made. The mask steps and the expected code bit flips, which the bench predicts from the monitor period it chooses for each trial. A window counter that runs long or short moves the first mask step and the rise of done away from the exact cycles of R2. A count that wraps or counts levels reverses whole decisions, so the final code at done differs from the expected value in most bits. An abort that fails to clear the window state shows as a first mask step earlier than a full window after enable.

// File: rtl/sarcal_pkg.sv
package sarcal_pkg;

   // Width needed to hold an index in 0..n-1 (at least one bit)
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sarcal_mon_sync.sv
module sarcal_mon_sync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic mon_in,
   output logic rise
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[0], mon_in};
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], mon_in};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sarcal_meas.sv
module sarcal_meas #(
   parameter int CNT_W      = 9,
   parameter int WIN_CYCLES = 1024
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             rise,
   output logic             win_end,
   output logic [CNT_W-1:0] count_total
);
   localparam int               WIN_W    = sarcal_pkg::idx_bits(WIN_CYCLES);
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   logic [WIN_W-1:0] win_q;
   logic [CNT_W-1:0] cnt_q;

   // The count includes this cycle's edge, so a window covers exactly WIN_CYCLES samples
   always_comb begin
      if (rise && (cnt_q != CNT_MAX)) count_total = cnt_q + 1'b1;
      else                            count_total = cnt_q;
   end

   assign win_end = run && (win_q == WIN_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         cnt_q <= '0;
      end else if (!run || win_end) begin
         win_q <= '0;
         cnt_q <= '0;
      end else begin
         win_q <= win_q + 1'b1;
         cnt_q <= count_total;
      end
   end
endmodule

// File: rtl/sarcal_sar.sv
module sarcal_sar #(
   parameter int CODE_W = 8,
   parameter int CNT_W  = 9
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              win_end,
   input  logic [CNT_W-1:0]  count_total,
   input  logic [CNT_W-1:0]  target,
   output logic [CODE_W-1:0] code,
   output logic [CODE_W-1:0] mask,
   output logic              done
);
   localparam logic [CODE_W-1:0] TOP_BIT = {1'b1, {(CODE_W-1){1'b0}}};

   logic              slow;
   logic [CODE_W-1:0] next_trial;

   assign slow       = count_total < target;
   assign next_trial = mask >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= TOP_BIT;
         mask <= TOP_BIT;
         done <= 1'b0;
      end else if (!enable) begin
         code <= TOP_BIT;
         mask <= TOP_BIT;
         done <= 1'b0;
      end else if (win_end && !done) begin
         if (slow) code <= code | next_trial;
         else      code <= (code & ~mask) | next_trial;
         mask <= next_trial;
         done <= mask[0];
      end
   end
endmodule

// File: rtl/sarcal_ctrl.sv
module sarcal_ctrl #(
   parameter int CODE_W      = 8,
   parameter int CNT_W       = 9,
   parameter int WIN_CYCLES  = 1024,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic              cal_en,
   input  logic              mon_clk,
   input  logic [CNT_W-1:0]  target_cnt,
   output logic [CODE_W-1:0] tune_code,
   output logic [CODE_W-1:0] trial_mask,
   output logic              cal_done
);
   if (CODE_W < 2) begin : g_bad_code_w
      $error("sarcal_ctrl: CODE_W must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("sarcal_ctrl: CNT_W must be at least 2");
   end
   if (WIN_CYCLES < 2) begin : g_bad_win
      $error("sarcal_ctrl: WIN_CYCLES must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sarcal_ctrl: SYNC_STAGES must be at least 2");
   end

   logic             mon_rise;
   logic             win_end;
   logic             run;
   logic [CNT_W-1:0] count_total;

   assign run = cal_en & ~cal_done;

   sarcal_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .mon_in (mon_clk),
      .rise   (mon_rise)
   );

   sarcal_meas #(.CNT_W(CNT_W), .WIN_CYCLES(WIN_CYCLES)) u_meas (
      .clk         (clk_ref),
      .rst_n       (rst_n),
      .run         (run),
      .rise        (mon_rise),
      .win_end     (win_end),
      .count_total (count_total)
   );

   sarcal_sar #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_sar (
      .clk         (clk_ref),
      .rst_n       (rst_n),
      .enable      (cal_en),
      .win_end     (win_end),
      .count_total (count_total),
      .target      (target_cnt),
      .code        (tune_code),
      .mask        (trial_mask),
      .done        (cal_done)
   );
endmodule

// File: rtl/sarcal_ctrl_chk.sv
module sarcal_ctrl_chk #(
   parameter int CODE_W = 8
)(
   input logic              clk_ref,
   input logic              rst_n,
   input logic              cal_en,
   input logic [CODE_W-1:0] tune_code,
   input logic [CODE_W-1:0] trial_mask,
   input logic              cal_done
);
   localparam logic [CODE_W-1:0] TOP_BIT = {1'b1, {(CODE_W-1){1'b0}}};
   localparam logic [CODE_W-1:0] ONE     = CODE_W'(1);
   localparam logic [CODE_W-1:0] NONE    = '0;

   p_idle_state_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !cal_en |=> (tune_code == TOP_BIT) && (trial_mask == TOP_BIT) && !cal_done);

   p_mask_onehot_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $onehot0(trial_mask));

   p_mask_walk_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $past(cal_en) && (trial_mask != $past(trial_mask)) |->
         trial_mask == ($past(trial_mask) >> 1));

   p_done_mask_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      cal_done |-> trial_mask == NONE);

   p_done_hold_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      cal_done && cal_en |=> cal_done && $stable(tune_code));

   p_done_after_lsb_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(cal_done) |-> $past(trial_mask) == ONE);

   p_trial_bit_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (trial_mask != NONE) |->
         ((tune_code & trial_mask) != NONE) && ((tune_code & (trial_mask - ONE)) == NONE));

   p_upper_kept_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $past(cal_en) && (trial_mask != $past(trial_mask)) |->
         ((tune_code ^ $past(tune_code)) & ~(($past(trial_mask) << 1) - ONE)) == NONE);
endmodule

bind sarcal_ctrl sarcal_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
   .clk_ref    (clk_ref),
   .rst_n      (rst_n),
   .cal_en     (cal_en),
   .tune_code  (tune_code),
   .trial_mask (trial_mask),
   .cal_done   (cal_done)
);

// File: tb/tb_sarcal_ctrl.sv
module tb_sarcal_ctrl;
   localparam int WIN = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cal_en = 1'b0;
   logic       mon_clk = 1'b0;
   logic [8:0] target_cnt = 9'd256;
   logic [7:0] tune_code;
   logic [7:0] trial_mask;
   logic       cal_done;

   int checks = 0;
   int errors = 0;

   // Monitor generator: toggles every 'half' reference cycles unless held
   int  half = 2;
   int  ph = 0;
   bit  mon_hold = 1'b0;
   bit  mon_lvl = 1'b0;

   sarcal_ctrl dut (
      .clk_ref    (clk),
      .rst_n      (rst_n),
      .cal_en     (cal_en),
      .mon_clk    (mon_clk),
      .target_cnt (target_cnt),
      .tune_code  (tune_code),
      .trial_mask (trial_mask),
      .cal_done   (cal_done)
   );

   always #5 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         if (mon_hold) begin
            mon_clk = mon_lvl;
            ph = 0;
         end else begin
            ph++;
            if (ph >= half) begin
               mon_clk = ~mon_clk;
               ph = 0;
            end
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(req, {23'd0, tune_code, cal_done}, {23'd0, 8'h80, 1'b0});
      chk(req, {24'd0, trial_mask}, 32'h80);
   endtask

   // Period per trial: bit 1 means slow (half 4, 128 edges), 0 means fast (half 2, 256 edges)
   function automatic int half_for(input logic [7:0] pat, input logic [7:0] m);
      for (int i = 0; i < 8; i++) if (m[i]) return pat[i] ? 4 : 2;
      return 2;
   endfunction

   // Runs one calibration; returns cycles to first mask step and to done
   task automatic run_cal(input logic [7:0] pat, input bit use_pat,
                          output int n_first, output int n_done);
      logic [7:0] prev;
      int n;
      n = 0; n_first = -1; n_done = -1;
      if (use_pat) half = half_for(pat, 8'h80);
      repeat (16) @(negedge clk);
      cal_en = 1'b1;
      prev = trial_mask;
      while (n < 9 * WIN) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (trial_mask != prev) begin
            if (n_first < 0) n_first = n;
            chk("R5 mask step", {24'd0, trial_mask}, {24'd0, prev >> 1});
            if (trial_mask != 8'h00) begin
               chk("R10 trial bit set", {31'd0, |(tune_code & trial_mask)}, 32'd1);
               chk("R10 lower bits clear", {24'd0, tune_code & (trial_mask - 8'd1)}, 32'd0);
               if (use_pat) half = half_for(pat, trial_mask);
            end
            prev = trial_mask;
         end
         if (cal_done) begin
            n_done = n;
            break;
         end
      end
   endtask

   task automatic finish_cal();
      @(negedge clk);
      cal_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      chk_idle("R1 in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_idle("R1 after reset");
   endtask

   task automatic t_idle_hold();
      half = 1;
      target_cnt = 9'd3;
      repeat (3000) @(negedge clk);
      chk_idle("R1 enable low holds state");
   endtask

   task automatic t_timing_keep();
      int nf, nd;
      mon_hold = 1'b0; half = 2; target_cnt = 9'd257;
      run_cal(8'h00, 1'b0, nf, nd);
      chk("R2 first window length", nf, WIN);
      chk("R2 done latency", nd, 8 * WIN);
      chk("R3 count 256 below target 257", {24'd0, tune_code}, 32'hFF);
      finish_cal();
   endtask

   task automatic t_equal_clear();
      int nf, nd;
      half = 2; target_cnt = 9'd256;
      run_cal(8'h00, 1'b0, nf, nd);
      chk("R4 count equal target clears", {24'd0, tune_code}, 32'h00);
      chk("R8 done after equal run", {31'd0, cal_done}, 32'd1);
      finish_cal();
   endtask

   task automatic t_pattern(input logic [7:0] pat);
      int nf, nd;
      target_cnt = 9'd200;
      run_cal(pat, 1'b1, nf, nd);
      chk("R3/R4 mixed decisions", {24'd0, tune_code}, {24'd0, pat});
      finish_cal();
   endtask

   task automatic t_saturate();
      int nf, nd;
      half = 1; target_cnt = 9'd511;
      run_cal(8'h00, 1'b0, nf, nd);
      chk("R7 512 edges saturate to 511", {24'd0, tune_code}, 32'h00);
      finish_cal();
   endtask

   task automatic t_level(input bit lvl);
      int nf, nd;
      mon_hold = 1'b1; mon_lvl = lvl; target_cnt = 9'd1;
      run_cal(8'h00, 1'b0, nf, nd);
      chk("R6 constant monitor counts zero", {24'd0, tune_code}, 32'hFF);
      finish_cal();
      mon_hold = 1'b0;
   endtask

   task automatic t_done_hold();
      int nf, nd;
      logic [7:0] held;
      half = 2; target_cnt = 9'd257;
      run_cal(8'h00, 1'b0, nf, nd);
      held = tune_code;
      half = 1; target_cnt = 9'd5;
      repeat (2000) @(negedge clk);
      chk("R8 code frozen after done", {24'd0, tune_code}, {24'd0, held});
      chk("R8 done stays high", {31'd0, cal_done}, 32'd1);
      chk("R5 mask zero when done", {24'd0, trial_mask}, 32'd0);
      finish_cal();
      chk_idle("R9 release after done");
   endtask

   task automatic t_abort();
      int nf, nd;
      half = 2; target_cnt = 9'd300;
      repeat (8) @(negedge clk);
      cal_en = 1'b1;
      repeat (WIN + WIN / 2) @(negedge clk);
      cal_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk_idle("R9 abort returns to start");
      run_cal(8'h00, 1'b0, nf, nd);
      chk("R9 fresh first window", nf, WIN);
      chk("R9 restarted result", {24'd0, tune_code}, 32'hFF);
      finish_cal();
   endtask

   initial begin
      t_reset();
      t_idle_hold();
      t_timing_keep();
      t_equal_clear();
      t_pattern(8'b1011_0010);
      t_pattern(8'b0110_1101);
      t_saturate();
      t_level(1'b1);
      t_level(1'b0);
      t_done_hold();
      t_abort();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule